// File: doc/BRIEF.md
# UART Sleep Handshake Controller

This block is the device-side handshake engine for a serial link that uses hardware flow control and modem-control lines to agree on a low-power state with a host. It drives the active-low clear-to-send line (`cts_n`) and the active-low data-set-ready line (`dsr_n`). It samples the host's active-low data-terminal-ready line (`dtr_n_in`) and raises a low-power enable (`lp_en`) for the device's power logic. Framing, baud timing, the receive buffer and the power switch itself sit outside the block.

Either party may propose sleep. The host proposes it by holding `dtr_n_in` high. The device proposes it by raising `loc_sleep_req`, which makes the block drive `dsr_n` high and wait for the host to agree with `dtr_n_in` high. Once both lines are high, `cts_n` is forced high for a fixed settling window, and then the sleep state is entered. Actual low power is only enabled while the device reports no pending activity on `busy`. The host wakes the device by pulling `dtr_n_in` low, and the device answers by pulling `dsr_n` low. When `sleep_en` is clear the whole negotiation is switched off and the block acts as plain flow control.

Top module: `uart_sleep_hs`

## Requirements
- R1: While no sleep negotiation is in progress, `cts_n` equals the value `rx_full` had one clock earlier (1 = buffer full, stop the host; 0 = ready).
- R2: During the pre-sleep window and the sleep state, `cts_n` is 1. Whenever `lp_en` is 1, both `cts_n` and `dsr_n` are 1.
- R3: `dtr_n_in` passes through a two-flop synchronizer and only takes effect after the same level is seen on two consecutive samples. A one-cycle pulse is ignored, and a pulse of two cycles or longer is accepted.
- R4: With `sleep_en` = 1, a settled high level on `dtr_n_in` (host request) drives `dsr_n` to 1 as acknowledgement. The block then enters sleep, where `lp_en` = 1 if `busy` = 0.
- R5: The pre-sleep window lasts `PRE_CYC` cycles, measured from the first cycle with `cts_n` = 1 to the first cycle with `lp_en` = 1 (default `PRE_CYC` = 4).
- R6: In the sleep state, `lp_en` equals the inverse of `busy` one clock earlier. `cts_n` and `dsr_n` stay 1 whatever `busy` and `rx_full` do.
- R7: With `sleep_en` = 1 and `dtr_n_in` low, raising `loc_sleep_req` drives `dsr_n` to 1 while `cts_n` keeps following `rx_full` and `lp_en` stays 0. Withdrawing the request returns `dsr_n` to 0.
- R8: After a device request, a host confirmation (`dtr_n_in` high) leads into the sleep state with `lp_en` = 1.
- R9: A settled low on `dtr_n_in` during sleep wakes the block. `dsr_n` returns to 0, `lp_en` to 0, and `cts_n` returns to 0 only once the block is active again and `rx_full` is 0.
- R10: With `sleep_en` = 0, `dsr_n` stays 0, `lp_en` stays 0 and `dtr_n_in` has no effect. Clearing `sleep_en` during sleep wakes the block.
- R11: While `rst` is high, `cts_n` = 1, `dsr_n` = 0 and `lp_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Enables the sleep negotiation |
| rx_full | input | 1 | Receive buffer cannot take more data |
| loc_sleep_req | input | 1 | Device asks for sleep |
| busy | input | 1 | Local activity pending; blocks low power |
| dtr_n_in | input | 1 | Host data-terminal-ready, active low, asynchronous |
| cts_n | output | 1 | Clear-to-send to host, active low |
| dsr_n | output | 1 | Data-set-ready to host, active low |
| lp_en | output | 1 | Low-power enable to device power logic |

## Verification
The bound checker watches, on every cycle, how the outputs relate to the internal state and to the previous inputs. It covers `cts_n` tracking `rx_full` while active, `cts_n` held high through pre-sleep and sleep, the line pattern while `lp_en` is high, `lp_en` following the inverse of `busy`, the wake reply on `dsr_n`, and the disabled mode. The bench scenarios are needed for the sequences that take many cycles. These are the synchronizer rejecting a one-cycle pulse but accepting a two-cycle one, the exact length of the pre-sleep window, the device-requested path through host confirmation, and wake-up with the buffer still full.

// File: rtl/slp_hs_pkg.sv
package slp_hs_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_SLP_REQ = 3'd1,
        ST_PRE     = 3'd2,
        ST_SLEEP   = 3'd3,
        ST_WAKE    = 3'd4
    } hs_state_e;

    typedef struct packed {
        logic cts_n;
        logic dsr_n;
        logic lp_en;
    } hs_lines_t;

    localparam hs_lines_t LINES_RST = '{cts_n: 1'b1, dsr_n: 1'b0, lp_en: 1'b0};

    // Line pattern the host and the power logic see for a given state.
    function automatic hs_lines_t decode_lines(hs_state_e st, logic rx_full, logic busy);
        hs_lines_t l;
        l = LINES_RST;
        unique case (st)
            ST_ACTIVE:  begin l.cts_n = rx_full; l.dsr_n = 1'b0; l.lp_en = 1'b0;  end
            ST_SLP_REQ: begin l.cts_n = rx_full; l.dsr_n = 1'b1; l.lp_en = 1'b0;  end
            ST_PRE:     begin l.cts_n = 1'b1;    l.dsr_n = 1'b1; l.lp_en = 1'b0;  end
            ST_SLEEP:   begin l.cts_n = 1'b1;    l.dsr_n = 1'b1; l.lp_en = ~busy; end
            ST_WAKE:    begin l.cts_n = 1'b1;    l.dsr_n = 1'b0; l.lp_en = 1'b0;  end
            default:    l = LINES_RST;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/slp_dtr_filter.sv
module slp_dtr_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        RST_LVL     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [MSB:0] chain;
    logic         hist;

    // Synchronizer chain, then a history flop. The output moves only when two
    // consecutive synchronized samples agree.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {SYNC_STAGES{RST_LVL}};
            hist  <= RST_LVL;
            dout  <= RST_LVL;
        end else begin
            chain <= {chain[MSB-1:0], din};
            hist  <= chain[MSB];
            if (chain[MSB] == hist) begin
                dout <= hist;
            end
        end
    end
endmodule

// File: rtl/slp_hs_fsm.sv
module slp_hs_fsm
    import slp_hs_pkg::*;
#(
    parameter int unsigned PRE_CYC = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_en,
    input  logic      host_slp,
    input  logic      loc_req,
    output hs_state_e state
);
    localparam int unsigned CW   = $clog2(PRE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PRE_CYC - 1);

    hs_state_e     nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (sleep_en) begin
                    if (host_slp)     nxt = ST_PRE;
                    else if (loc_req) nxt = ST_SLP_REQ;
                end
            end
            ST_SLP_REQ: begin
                if (!sleep_en || (!loc_req && !host_slp)) nxt = ST_ACTIVE;
                else if (host_slp)                         nxt = ST_PRE;
            end
            ST_PRE: begin
                if (!sleep_en || !host_slp) nxt = ST_WAKE;
                else if (cnt == LAST)       nxt = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (!sleep_en || !host_slp) nxt = ST_WAKE;
            end
            ST_WAKE:  nxt = ST_ACTIVE;
            default:  nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_PRE) cnt <= cnt + 1'b1;
            else                 cnt <= '0;
        end
    end
endmodule

// File: rtl/slp_line_drv.sv
module slp_line_drv
    import slp_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hs_state_e state,
    input  logic      rx_full,
    input  logic      busy,
    output hs_lines_t lines
);
    always_ff @(posedge clk) begin
        if (rst) lines <= LINES_RST;
        else     lines <= decode_lines(state, rx_full, busy);
    end
endmodule

// File: rtl/uart_sleep_hs.sv
module uart_sleep_hs
    import slp_hs_pkg::*;
#(
    parameter int unsigned PRE_CYC     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_en,
    input  logic rx_full,
    input  logic loc_sleep_req,
    input  logic busy,
    input  logic dtr_n_in,
    output logic cts_n,
    output logic dsr_n,
    output logic lp_en
);
    logic      host_slp;
    hs_state_e st_q;
    hs_lines_t lines;

    slp_dtr_filter #(.SYNC_STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .din  (dtr_n_in),
        .dout (host_slp)
    );

    slp_hs_fsm #(.PRE_CYC(PRE_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sleep_en (sleep_en),
        .host_slp (host_slp),
        .loc_req  (loc_sleep_req),
        .state    (st_q)
    );

    slp_line_drv u_drv (
        .clk     (clk),
        .rst     (rst),
        .state   (st_q),
        .rx_full (rx_full),
        .busy    (busy),
        .lines   (lines)
    );

    assign cts_n = lines.cts_n;
    assign dsr_n = lines.dsr_n;
    assign lp_en = lines.lp_en;
endmodule

// File: rtl/uart_sleep_hs_chk.sv
module uart_sleep_hs_chk
    import slp_hs_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sleep_en,
    input logic      rx_full,
    input logic      busy,
    input logic      cts_n,
    input logic      dsr_n,
    input logic      lp_en,
    input hs_state_e state
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_active_cts_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE) |=> (cts_n == $past(rx_full)));

    p_sleep_cts_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE || state == ST_SLEEP) |=> cts_n);

    p_lp_lines_r2: assert property (@(posedge clk) disable iff (rst)
        lp_en |-> (cts_n && dsr_n));

    p_lp_busy_r6: assert property (@(posedge clk) disable iff (rst)
        lp_en |-> !$past(busy));

    p_wake_reply_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE) |=> (!dsr_n && !lp_en));

    p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !sleep_en && $past(!sleep_en)) |=> (!dsr_n && !lp_en));

    p_state_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_ACTIVE, ST_SLP_REQ, ST_PRE, ST_SLEEP, ST_WAKE}));
endmodule

bind uart_sleep_hs uart_sleep_hs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sleep_en (sleep_en),
    .rx_full  (rx_full),
    .busy     (busy),
    .cts_n    (cts_n),
    .dsr_n    (dsr_n),
    .lp_en    (lp_en),
    .state    (st_q)
);

// File: tb/uart_sleep_hs_tb.sv
module uart_sleep_hs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_CYC    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_en = 1'b0, rx_full = 1'b0, loc_req = 1'b0, busy = 1'b0, dtr_n_in = 1'b0;
    logic cts_n, dsr_n, lp_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_sleep_hs #(.PRE_CYC(PRE_CYC)) u_dut (
        .clk(clk), .rst(rst), .sleep_en(sleep_en), .rx_full(rx_full),
        .loc_sleep_req(loc_req), .busy(busy), .dtr_n_in(dtr_n_in),
        .cts_n(cts_n), .dsr_n(dsr_n), .lp_en(lp_en)
    );

    // Expected {cts_n, dsr_n, lp_en} for the phases the bench drives.
    function automatic logic [2:0] exp_active(logic rx);
        return {rx, 1'b0, 1'b0};
    endfunction
    function automatic logic [2:0] exp_sleep(logic bz);
        return {1'b1, 1'b1, ~bz};
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {cts_n,dsr_n,lp_en} got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int first_cts, first_lp, saw_dsr, bad_pulse;
        void'($urandom(32'h5EED_0042));

        // R11: reset values
        wait_cyc(3);
        check("R11 reset lines", {cts_n, dsr_n, lp_en}, 3'b100);
        rst = 1'b0;

        // R1 / R10: disabled negotiation, random inputs
        for (int i = 0; i < 200; i++) begin
            rx_full  = 1'($urandom);
            dtr_n_in = 1'($urandom);
            loc_req  = 1'($urandom);
            busy     = 1'($urandom);
            @(negedge clk);
            check("R1/R10 flow control while disabled", {cts_n, dsr_n, lp_en}, exp_active(rx_full));
        end

        // R3: one-cycle dtr pulse is ignored
        rx_full = 0; loc_req = 0; busy = 0; dtr_n_in = 0; sleep_en = 1;
        wait_cyc(8);
        check("R3 settled active", {cts_n, dsr_n, lp_en}, exp_active(1'b0));
        dtr_n_in = 1'b1;
        @(negedge clk);
        dtr_n_in = 1'b0;
        bad_pulse = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (dsr_n || cts_n) bad_pulse++;
        end
        check_int("R3 short pulse ignored", bad_pulse, 0);

        // R4 / R5: host request, pre-sleep window length
        dtr_n_in = 1'b1;
        first_cts = -1; first_lp = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cts_n && first_cts < 0) first_cts = i;
            if (lp_en && first_lp < 0)  first_lp  = i;
        end
        check_int("R5 pre-sleep window", first_lp - first_cts, PRE_CYC);
        check("R4 host sleep entered", {cts_n, dsr_n, lp_en}, exp_sleep(1'b0));

        // R6: busy gates low power, lines stay high
        for (int i = 0; i < 100; i++) begin
            busy    = 1'($urandom);
            rx_full = 1'($urandom);
            @(negedge clk);
            check("R6 busy gating in sleep", {cts_n, dsr_n, lp_en}, exp_sleep(busy));
        end
        busy = 0;

        // R9: host wake with buffer still full
        rx_full  = 1'b1;
        dtr_n_in = 1'b0;
        wait_cyc(12);
        check("R9 woken, buffer full", {cts_n, dsr_n, lp_en}, exp_active(1'b1));
        rx_full = 1'b0;
        wait_cyc(2);
        check("R9 woken, buffer drained", {cts_n, dsr_n, lp_en}, exp_active(1'b0));

        // R7: device request and withdrawal
        loc_req = 1'b1;
        wait_cyc(4);
        check("R7 device request", {cts_n, dsr_n, lp_en}, 3'b010);
        rx_full = 1'b1;
        wait_cyc(2);
        check("R7 flow control during request", {cts_n, dsr_n, lp_en}, 3'b110);
        rx_full = 1'b0;
        loc_req = 1'b0;
        wait_cyc(3);
        check("R7 request withdrawn", {cts_n, dsr_n, lp_en}, exp_active(1'b0));

        // R8: device request confirmed by host
        loc_req = 1'b1;
        wait_cyc(4);
        dtr_n_in = 1'b1;
        wait_cyc(PRE_CYC + 10);
        check("R8 confirmed sleep", {cts_n, dsr_n, lp_en}, exp_sleep(1'b0));
        loc_req = 1'b0;
        wait_cyc(3);
        check("R8 sleep holds after request drop", {cts_n, dsr_n, lp_en}, exp_sleep(1'b0));

        // R10: clearing enable wakes; dtr high is then ignored
        sleep_en = 1'b0;
        wait_cyc(5);
        check("R10 enable cleared wakes", {cts_n, dsr_n, lp_en}, exp_active(1'b0));
        wait_cyc(20);
        check("R10 dtr high ignored", {cts_n, dsr_n, lp_en}, exp_active(1'b0));

        // R3: two-cycle pulse is accepted
        dtr_n_in = 1'b0;
        wait_cyc(8);
        sleep_en = 1'b1;
        wait_cyc(3);
        dtr_n_in = 1'b1;
        wait_cyc(2);
        dtr_n_in = 1'b0;
        saw_dsr = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (dsr_n) saw_dsr = 1;
        end
        check_int("R3 two-cycle pulse accepted", saw_dsr, 1);
        wait_cyc(6);
        check("R3 back to active", {cts_n, dsr_n, lp_en}, exp_active(1'b0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule